// File: doc/BRIEF.md
# Active Tamper Mesh Checker

This block drives up to six external sensor loops, such as conductive traces wrapped around a protected area. Each loop carries a pseudo-random bit pattern from the block and back. The block puts a 16-bit LFSR pattern on each loop output. It samples the returning input on every tick of its internal clock and counts the ticks in the current bit period where the returned bit differs from the bit sent. When that count reaches a programmable threshold on an enabled loop, a sticky alarm for that loop is set.

A warning flag for each loop records any mismatch, whether or not the loop is enabled. The alarm itself is gated by the loop's enable. A combined tamper output is high while any alarm is set. All logic runs on the slow base clock, gated by a prescaler tick. The bit period is a selectable number of ticks. A software clear for each loop wipes that loop's alarm, warning and mismatch count, which re-arms the loop.

Top module: `tamper_mesh_checker`

## Requirements
- R1: While rst_n is low, alarm and warn are 0 and each LFSR holds its seed. Seed i is 16'hACE1 XOR ((i+1) times 16'h1111), so loop_out resets to 6'b101010.
- R2: A free-running 6-bit counter counts base clock edges from reset. A tick occurs on an edge where the counter's low k bits are all ones, with k = prescale (code 7 is taken as 6). A tick therefore occurs every 2^k base clocks. State other than the prescale counter changes only on ticks, except for clears.
- R3: The bit period is 4 << r ticks, with r = rate_sel (code 7 is taken as 6, i.e. 256 ticks). The period ends on the tick where the low bits of a tick counter started at reset are all ones. At that tick every LFSR shifts right, with the new bit 15 = bit0 ^ bit2 ^ bit3 ^ bit5. loop_out[i] is bit 0 of LFSR i.
- R4: On each tick where loop_in[i] != loop_out[i], the mismatch count of pair i goes up by one, saturating at 31. The count returns to 0 after the last tick of each bit period.
- R5: On a mismatch tick where the count including this mismatch is at least thresh, an enabled pair sets its alarm. A threshold of 0 behaves as 1.
- R6: A pair whose loop_en bit is 0 never sets its alarm, even under continuous mismatch.
- R7: warn[i] is set on any mismatch tick of pair i, whatever loop_en[i] is.
- R8: alarm and warn stay set until alarm_clr[i] is seen on a base clock edge. That edge clears alarm, warn and the mismatch count of pair i, and the clear wins over a set in the same cycle.
- R9: tamper_any is high exactly when any alarm bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 6 | Per-pair alarm enable |
| thresh | input | 5 | Mismatch count that raises an alarm |
| rate_sel | input | 3 | Bit period select, 4 << code ticks |
| prescale | input | 3 | Tick divider, 2^code base clocks |
| loop_in | input | 6 | Returned loop inputs |
| alarm_clr | input | 6 | Per-pair clear of alarm, warning and count |
| loop_out | output | 6 | Loop drive bits |
| alarm | output | 6 | Sticky per-pair tamper alarms |
| warn | output | 6 | Sticky per-pair mismatch warnings |
| tamper_any | output | 1 | OR of all alarms |

## Verification
The bench feeds a fault pattern that alternates every tick on one loop, so every period sees exactly two mismatches whatever its phase. A design that failed to clear the count at the period boundary would accumulate these into a false alarm at threshold three. A disabled loop held in constant mismatch shows whether enable gating was placed on the warning instead of the alarm. A clear driven in the same cycle as a mismatch catches a design where the set wins over the clear. Runs with prescale and rate changes, including the reserved rate code and threshold 0, expose wrong tick spacing, because the loop pattern advances at the wrong edge compared with the model.

// File: rtl/tamper_mesh_checker.sv
module tamper_mesh_checker #(
  parameter int NPAIR = 6,
  parameter int CW    = 5,
  parameter int LW    = 16,
  parameter int PW    = 6,
  parameter int BW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] loop_en,
  input  logic [CW-1:0]    thresh,
  input  logic [2:0]       rate_sel,
  input  logic [2:0]       prescale,
  input  logic [NPAIR-1:0] loop_in,
  input  logic [NPAIR-1:0] alarm_clr,
  output logic [NPAIR-1:0] loop_out,
  output logic [NPAIR-1:0] alarm,
  output logic [NPAIR-1:0] warn,
  output logic             tamper_any
);
  localparam logic [LW-1:0] SEED_BASE = LW'(16'hACE1);
  localparam logic [CW-1:0] CNT_MAX   = {CW{1'b1}};

  logic [PW-1:0] pre_cnt;
  logic [BW-1:0] bit_cnt;
  logic [2:0]    ps_eff, rs_eff;
  logic [PW-1:0] pmask;
  logic [BW-1:0] bmask;
  logic          tick, period_end;

  assign ps_eff     = (prescale == 3'd7) ? 3'd6 : prescale;
  assign rs_eff     = (rate_sel == 3'd7) ? 3'd6 : rate_sel;
  assign pmask      = PW'(({1'b0, {PW{1'b0}}} | (PW+1)'(1)) << ps_eff) - PW'(1);
  assign bmask      = BW'(((BW+1)'(4) << rs_eff) - (BW+1)'(1));
  assign tick       = (pre_cnt & pmask) == pmask;
  assign period_end = tick && ((bit_cnt & bmask) == bmask);
  assign tamper_any = |alarm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
      if (tick) bit_cnt <= bit_cnt + BW'(1);
    end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    localparam logic [LW-1:0] SEED = SEED_BASE ^ LW'((i + 1) * 16'h1111);
    logic [LW-1:0] lfsr;
    logic [CW-1:0] cnt;
    logic          mis, hit;

    assign loop_out[i] = lfsr[0];
    assign mis = loop_in[i] ^ lfsr[0];
    assign hit = tick && mis && ({1'b0, cnt} + (CW+1)'(1) >= {1'b0, thresh});

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lfsr <= SEED;
      else if (period_end) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[LW-1:1]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt      <= '0;
        alarm[i] <= 1'b0;
        warn[i]  <= 1'b0;
      end else if (alarm_clr[i]) begin
        cnt      <= '0;
        alarm[i] <= 1'b0;
        warn[i]  <= 1'b0;
      end else if (tick) begin
        if (period_end)              cnt <= '0;
        else if (mis && cnt != CNT_MAX) cnt <= cnt + CW'(1);
        if (mis)               warn[i]  <= 1'b1;
        if (hit && loop_en[i]) alarm[i] <= 1'b1;
      end

    assert_disabled_no_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm[i] && !loop_en[i]) |=> !alarm[i]);
    assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm[i] && !alarm_clr[i]) |=> alarm[i]);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_clr[i] |=> (!alarm[i] && !warn[i] && cnt == '0));
    assert_warn_on_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mis && !alarm_clr[i]) |=> warn[i]);
    assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> cnt == '0);
  end

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(loop_out));
  assert_any_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tamper_any) |-> (alarm != '0));
endmodule

// File: tb/test_tamper_mesh_checker.sv
module test_tamper_mesh_checker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] loop_en = '0, loop_in, alarm_clr = '0, loop_out, alarm, warn, flip = '0;
  logic [4:0] thresh = 5'd3;
  logic [2:0] rate_sel = '0, prescale = '0;
  logic       tamper_any;
  int         n_chk = 0, n_fail = 0;

  int m_pre, m_bit, m_lfsr[6], m_cnt[6];
  bit m_alarm[6], m_warn[6];

  assign loop_in = loop_out ^ flip;

  tamper_mesh_checker i_tamper_mesh_checker (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .thresh(thresh),
    .rate_sel(rate_sel), .prescale(prescale), .loop_in(loop_in),
    .alarm_clr(alarm_clr), .loop_out(loop_out), .alarm(alarm),
    .warn(warn), .tamper_any(tamper_any));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_reset();
    m_pre = 0; m_bit = 0;
    for (int i = 0; i < 6; i++) begin
      m_lfsr[i] = 16'hACE1 ^ (((i + 1) * 16'h1111) & 16'hFFFF);
      m_cnt[i] = 0; m_alarm[i] = 0; m_warn[i] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int k, r, tk, plen;
      bit pend;
      k = (prescale == 7) ? 6 : prescale;
      r = (rate_sel == 7) ? 6 : rate_sel;
      plen = 4 * (2 ** r);
      tk = ((m_pre % (2 ** k)) == (2 ** k) - 1);
      pend = tk && ((m_bit % plen) == plen - 1);
      m_pre = (m_pre + 1) % 64;
      for (int i = 0; i < 6; i++) begin
        if (alarm_clr[i]) begin
          m_cnt[i] = 0; m_alarm[i] = 0; m_warn[i] = 0;
        end else if (tk) begin
          if (flip[i]) begin
            m_warn[i] = 1;
            if (loop_en[i] && m_cnt[i] + 1 >= thresh) m_alarm[i] = 1;
          end
          if (pend) m_cnt[i] = 0;
          else if (flip[i] && m_cnt[i] < 31) m_cnt[i]++;
        end
      end
      if (pend)
        for (int i = 0; i < 6; i++) begin
          int b0, b2, b3, b5;
          b0 = m_lfsr[i] % 2; b2 = (m_lfsr[i] / 4) % 2;
          b3 = (m_lfsr[i] / 8) % 2; b5 = (m_lfsr[i] / 32) % 2;
          m_lfsr[i] = (m_lfsr[i] / 2) + ((b0 ^ b2 ^ b3 ^ b5) * 32768);
        end
      if (tk) m_bit = (m_bit + 1) % 256;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [5:0] eo, ea, ew;
    for (int i = 0; i < 6; i++) begin
      eo[i] = m_lfsr[i][0]; ea[i] = m_alarm[i]; ew[i] = m_warn[i];
    end
    check("R3 loop_out", loop_out, eo);
    check("R5 alarm", alarm, ea);
    check("R7 warn", warn, ew);
    check("R9 tamper_any", tamper_any, |ea);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(2);
    check("R1 reset loop_out", loop_out, 6'b101010);
    check("R1 reset alarm", alarm, 0);
    check("R1 reset warn", warn, 0);
    rst_n = 1'b1;
    loop_en = 6'b111101; thresh = 5'd3;
    wait_cyc(40);
    check("R3 clean loops no alarm", alarm, 0);
    for (int c = 0; c < 40; c++) begin flip[0] = ~flip[0]; wait_cyc(1); end
    check("R4 two per period stays below 3", alarm[0], 0);
    check("R7 warn on mismatch", warn[0], 1);
    thresh = 5'd2;
    for (int c = 0; c < 8; c++) begin flip[0] = ~flip[0]; wait_cyc(1); end
    flip[0] = 0;
    check("R5 alarm at threshold", alarm[0], 1);
    check("R9 any set", tamper_any, 1);
    flip[1] = 1; wait_cyc(20);
    check("R6 disabled pair no alarm", alarm[1], 0);
    check("R7 disabled pair warns", warn[1], 1);
    flip[1] = 0; wait_cyc(20);
    check("R8 alarm sticky", alarm[0], 1);
    alarm_clr = 6'b000011; flip[0] = 1; wait_cyc(1);
    alarm_clr = 0; flip[0] = 0;
    check("R8 clear wins alarm", alarm[0], 0);
    check("R8 clear wins warn", warn[0], 0);
    check("R9 none set", tamper_any, 0);
    prescale = 3'd2; rate_sel = 3'd1; thresh = 5'd5; flip[2] = 1;
    wait_cyc(80); flip[2] = 0; wait_cyc(8);
    check("R2 slow ticks alarm", alarm[2], 1);
    alarm_clr = 6'h3F; prescale = 0; rate_sel = 3'd7; thresh = 0; wait_cyc(1);
    alarm_clr = 0; flip[3] = 1; wait_cyc(1); flip[3] = 0; wait_cyc(1);
    check("R5 threshold zero", alarm[3], 1);
    for (int c = 0; c < 600; c++) begin
      flip = 6'($urandom);
      if (c % 50 == 0) alarm_clr = 6'($urandom); else alarm_clr = 0;
      if (c % 100 == 0) begin
        prescale = 3'($urandom); rate_sel = 3'($urandom % 3);
        thresh = 5'($urandom % 6); loop_en = 6'($urandom);
      end
      wait_cyc(1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule